// File: doc/BRIEF.md
# Processor Clock-State Controller

This block tracks the clock state of a processor core and decides when its clock may run. It keeps five named states: Normal (executing), Auto Halt (idle, entered by a software halt strobe), Quick Start (clock stopped by hardware through an active-low stop-clock level), Halt/Grant Snoop (a short service state for bus snoops that arrive during a low-power state), and Deep Sleep (clock fully stopped through an active-low sleep level, with no snooping). Each way out of a low-power state has its own latency, held in a parameterised down-counter and expressed in clock cycles derived from an assumed clock frequency in MHz.

Named transitions: *halt-entry* (Normal to Auto Halt on `halt_req`), *stop-entry* (Normal to Quick Start while `stop_clk_n` is low), *halt-exit* (Auto Halt to Normal after the halt exit latency, started by `wake_req`), *stop-exit* (Quick Start to Normal after the stop exit latency, started when `stop_clk_n` is high), *snoop-entry* (Auto Halt or Quick Start to Halt/Grant Snoop on `snoop_req`), *snoop-return* (Halt/Grant Snoop back to the state it came from, a fixed number of cycles after `snoop_done`), *sleep-entry* (Quick Start to Deep Sleep while `sleep_n` is low) and *sleep-exit* (Deep Sleep to Quick Start after the sleep exit latency, started when `sleep_n` is high). The outputs report the state, a core-clock enable, a snoop acknowledge and an enable for a time-stamp counter.

Top module: `clkstate_ctrl`

## Requirements
- R1: After reset the state is Normal (code 0), with `core_clk_en` = 1, `tsc_en` = 1 and `snoop_ack` = 0 while `snoop_req` is low. State codes: Normal 0, Auto Halt 1, Quick Start 2, Halt/Grant Snoop 3, Deep Sleep 4.
- R2: In Normal, `stop_clk_n` low sampled at a clock edge moves the state to Quick Start at that edge; otherwise `halt_req` high moves it to Auto Halt. Stop-clock wins when both are present.
- R3: In Auto Halt, `wake_req` sampled at an edge starts the halt exit; the state becomes Normal exactly AH_EXIT_US×CLK_MHZ edges later.
- R4: In Quick Start, `stop_clk_n` high sampled at an edge starts the stop exit; the state becomes Normal exactly QS_EXIT_US×CLK_MHZ edges later.
- R5: In Normal, `snoop_ack` follows `snoop_req` in the same cycle with no state change. In Auto Halt or Quick Start (no exit running), `snoop_req` moves the state to Halt/Grant Snoop at the next edge; `snoop_ack` is 1 throughout Halt/Grant Snoop.
- R6: In Halt/Grant Snoop, `snoop_done` sampled at an edge starts the return; exactly SNOOP_RET_CYC edges later the state is the one from which the snoop entered.
- R7: In Quick Start (no exit running, no snoop request), `sleep_n` low moves the state to Deep Sleep at the next edge; in Deep Sleep, `sleep_n` high sampled at an edge returns the state to Quick Start exactly DS_EXIT_US×CLK_MHZ edges later. Snoop has priority over sleep-entry, which has priority over stop-exit.
- R8: In Deep Sleep, `snoop_req` is ignored: `snoop_ack` stays 0 and the state stays Deep Sleep.
- R9: `core_clk_en` is 1 in Normal and in the last cycle of a halt or stop exit countdown, and 0 in every other cycle.
- R10: `tsc_en` is 1 only in Normal and Auto Halt; it is 0 in Quick Start, Halt/Grant Snoop and Deep Sleep.
- R11: While any countdown (exit or snoop return) runs, `halt_req`, `wake_req`, `snoop_req`, `snoop_done`, `stop_clk_n` and `sleep_n` have no effect; the state holds, `snoop_ack` stays 0 outside Halt/Grant Snoop, and the countdown completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Software halt strobe |
| wake_req | input | 1 | Wake event that ends Auto Halt |
| stop_clk_n | input | 1 | Active-low hardware stop-clock level |
| sleep_n | input | 1 | Active-low hardware sleep level |
| snoop_req | input | 1 | Bus snoop request |
| snoop_done | input | 1 | Bus snoop completion strobe |
| cur_state | output | 3 | Current state code |
| core_clk_en | output | 1 | Core clock enable |
| snoop_ack | output | 1 | Snoop accepted |
| tsc_en | output | 1 | Time-stamp counter enable |

## Verification
The hardest situation to reach is a snoop return into the correct origin when the origin is Quick Start and `sleep_n` is already low, so the return is followed at once by sleep-entry, together with request inputs toggling in the middle of a running countdown. Directed sequences walk each named transition and place snoop and halt strobes inside countdowns; a seeded random phase then toggles the two hardware levels rarely and the strobes often, so the machine keeps crossing between low-power states with countdowns in flight, and every cycle is compared with a bench model of the requirements.

// File: rtl/clkstate_pkg.sv
package clkstate_pkg;

    typedef enum logic [2:0] {
        CS_NORMAL   = 3'd0,
        CS_AUTOHALT = 3'd1,
        CS_QSTART   = 3'd2,
        CS_SNOOP    = 3'd3,
        CS_DSLEEP   = 3'd4
    } cstate_e;

endpackage

// File: rtl/clkstate_timer.sv
// Down-counter for exit and snoop-return latencies.
module clkstate_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         last
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= load_val;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign last = busy && (cnt == '0);

endmodule

// File: rtl/clkstate_outdec.sv
// Output decode from the registered state.
module clkstate_outdec
    import clkstate_pkg::*;
(
    input  cstate_e state,
    input  logic    last,
    input  logic    snoop_req,
    output logic    core_clk_en,
    output logic    snoop_ack,
    output logic    tsc_en
);

    always_comb begin
        core_clk_en = 1'b0;
        snoop_ack   = 1'b0;
        tsc_en      = 1'b0;
        unique case (state)
            CS_NORMAL: begin
                core_clk_en = 1'b1;
                snoop_ack   = snoop_req;
                tsc_en      = 1'b1;
            end
            CS_AUTOHALT: begin
                core_clk_en = last;
                tsc_en      = 1'b1;
            end
            CS_QSTART:  core_clk_en = last;
            CS_SNOOP:   snoop_ack   = 1'b1;
            CS_DSLEEP:  ;
            default:    ;
        endcase
    end

endmodule

// File: rtl/clkstate_ctrl.sv
module clkstate_ctrl
    import clkstate_pkg::*;
#(
    parameter int CLK_MHZ       = 200,
    parameter int AH_EXIT_US    = 10,
    parameter int QS_EXIT_US    = 10,
    parameter int DS_EXIT_US    = 30,
    parameter int SNOOP_RET_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       wake_req,
    input  logic       stop_clk_n,
    input  logic       sleep_n,
    input  logic       snoop_req,
    input  logic       snoop_done,
    output logic [2:0] cur_state,
    output logic       core_clk_en,
    output logic       snoop_ack,
    output logic       tsc_en
);

    localparam int AH_CYC  = AH_EXIT_US * CLK_MHZ;
    localparam int QS_CYC  = QS_EXIT_US * CLK_MHZ;
    localparam int DS_CYC  = DS_EXIT_US * CLK_MHZ;
    localparam int MAX_A   = (AH_CYC > QS_CYC) ? AH_CYC : QS_CYC;
    localparam int MAX_B   = (DS_CYC > SNOOP_RET_CYC) ? DS_CYC : SNOOP_RET_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] AH_LD  = CNT_W'(AH_CYC - 1);
    localparam logic [CNT_W-1:0] QS_LD  = CNT_W'(QS_CYC - 1);
    localparam logic [CNT_W-1:0] DS_LD  = CNT_W'(DS_CYC - 1);
    localparam logic [CNT_W-1:0] RET_LD = CNT_W'(SNOOP_RET_CYC - 1);

    cstate_e          state, nxt_state, saved;
    logic             save_origin;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             busy, last;

    // State register and snoop origin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CS_NORMAL;
            saved <= CS_NORMAL;
        end else begin
            state <= nxt_state;
            if (save_origin) saved <= state;
        end
    end

    // Transition logic.
    always_comb begin
        nxt_state   = state;
        save_origin = 1'b0;
        ld          = 1'b0;
        ld_val      = '0;
        unique case (state)
            CS_NORMAL: begin
                if (!stop_clk_n)   nxt_state = CS_QSTART;
                else if (halt_req) nxt_state = CS_AUTOHALT;
            end
            CS_AUTOHALT: begin
                if (busy) begin
                    if (last) nxt_state = CS_NORMAL;
                end else if (snoop_req) begin
                    nxt_state   = CS_SNOOP;
                    save_origin = 1'b1;
                end else if (wake_req) begin
                    ld     = 1'b1;
                    ld_val = AH_LD;
                end
            end
            CS_QSTART: begin
                if (busy) begin
                    if (last) nxt_state = CS_NORMAL;
                end else if (snoop_req) begin
                    nxt_state   = CS_SNOOP;
                    save_origin = 1'b1;
                end else if (!sleep_n) begin
                    nxt_state = CS_DSLEEP;
                end else if (stop_clk_n) begin
                    ld     = 1'b1;
                    ld_val = QS_LD;
                end
            end
            CS_SNOOP: begin
                if (busy) begin
                    if (last) nxt_state = saved;
                end else if (snoop_done) begin
                    ld     = 1'b1;
                    ld_val = RET_LD;
                end
            end
            CS_DSLEEP: begin
                if (busy) begin
                    if (last) nxt_state = CS_QSTART;
                end else if (sleep_n) begin
                    ld     = 1'b1;
                    ld_val = DS_LD;
                end
            end
            default: nxt_state = CS_NORMAL;
        endcase
    end

    clkstate_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .busy     (busy),
        .last     (last)
    );

    clkstate_outdec u_outdec (
        .state       (state),
        .last        (last),
        .snoop_req   (snoop_req),
        .core_clk_en (core_clk_en),
        .snoop_ack   (snoop_ack),
        .tsc_en      (tsc_en)
    );

    assign cur_state = state;

endmodule

// File: rtl/clkstate_ctrl_chk.sv
module clkstate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state,
    input logic [2:0] saved,
    input logic       busy,
    input logic       core_clk_en,
    input logic       snoop_ack,
    input logic       tsc_en
);

    localparam logic [2:0] S_NORM = 3'd0;
    localparam logic [2:0] S_QS   = 3'd2;
    localparam logic [2:0] S_SNP  = 3'd3;
    localparam logic [2:0] S_DS   = 3'd4;

    // R8: no acknowledge in Deep Sleep
    p_ds_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DS) |-> !snoop_ack);

    // R10: counter enable off in stopped and snoop states
    p_tsc_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_QS || state == S_DS || state == S_SNP) |-> !tsc_en);

    // R9: clock enable already high in the cycle before Normal is entered
    p_clken_lead_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_NORM && $past(state) != S_NORM) |-> $past(core_clk_en));

    // R7: Deep Sleep only leaves toward Quick Start
    p_ds_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_DS) |-> (state == S_DS || state == S_QS));

    // R6: snoop service returns to the saved origin
    p_snoop_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_SNP && state != S_SNP) |-> (state == $past(saved)));

    // R5: acknowledge held through the snoop state
    p_snoop_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SNP) |-> snoop_ack);

    // R11: state holds while a countdown is running
    p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(state));

endmodule

bind clkstate_ctrl clkstate_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .saved       (saved),
    .busy        (busy),
    .core_clk_en (core_clk_en),
    .snoop_ack   (snoop_ack),
    .tsc_en      (tsc_en)
);

// File: tb/clkstate_ctrl_tb.sv
`timescale 1ns/1ps
module clkstate_ctrl_tb;

    localparam int MHZ = 1;
    localparam int AH  = 10 * MHZ;
    localparam int QS  = 10 * MHZ;
    localparam int DS  = 30 * MHZ;
    localparam int RET = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0, wake_req = 1'b0, stop_clk_n = 1'b1, sleep_n = 1'b1;
    logic       snoop_req = 1'b0, snoop_done = 1'b0;
    logic [2:0] cur_state;
    logic       core_clk_en, snoop_ack, tsc_en;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    int m_st = 0, m_rem = 0, m_dst = 0, m_sv = 0;

    always #2.5 clk = ~clk;

    clkstate_ctrl #(.CLK_MHZ(MHZ), .SNOOP_RET_CYC(RET)) u_dut (
        .clk (clk), .rst_n (rst_n), .halt_req (halt_req), .wake_req (wake_req),
        .stop_clk_n (stop_clk_n), .sleep_n (sleep_n), .snoop_req (snoop_req),
        .snoop_done (snoop_done), .cur_state (cur_state), .core_clk_en (core_clk_en),
        .snoop_ack (snoop_ack), .tsc_en (tsc_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_clk(input int st, input int rem);
        return (st == 0 || ((st == 1 || st == 2) && rem == 1)) ? 1 : 0;
    endfunction

    function automatic int exp_tsc(input int st);
        return (st == 0 || st == 1) ? 1 : 0;
    endfunction

    function automatic int exp_ack(input int st, input logic req);
        return (st == 3 || (st == 0 && req)) ? 1 : 0;
    endfunction

    // Model of the requirements, advanced once per clock edge.
    task automatic model_edge();
        if (!rst_n) begin
            m_st = 0; m_rem = 0; m_sv = 0;
        end else if (m_rem > 0) begin
            m_rem--;
            if (m_rem == 0) m_st = m_dst;
        end else begin
            case (m_st)
                0: if (!stop_clk_n) m_st = 2; else if (halt_req) m_st = 1;
                1: if (snoop_req) begin m_sv = 1; m_st = 3; end
                   else if (wake_req) begin m_rem = AH; m_dst = 0; end
                2: if (snoop_req) begin m_sv = 2; m_st = 3; end
                   else if (!sleep_n) m_st = 4;
                   else if (stop_clk_n) begin m_rem = QS; m_dst = 0; end
                3: if (snoop_done) begin m_rem = RET; m_dst = m_sv; end
                4: if (sleep_n) begin m_rem = DS; m_dst = 2; end
                default: m_st = 0;
            endcase
        end
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        #1;
        if (rst_n) begin
            check("model state", int'(cur_state), m_st);
            check("model R9 clk_en", int'(core_clk_en), exp_clk(m_st, m_rem));
            check("model R10 tsc_en", int'(tsc_en), exp_tsc(m_st));
            check("model R5 ack", int'(snoop_ack), exp_ack(m_st, snoop_req));
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        ticks(3);
        rst_n = 1'b1;
        model_edge();
        // R1 reset state
        check("R1 state", int'(cur_state), 0);
        check("R1 clk_en", int'(core_clk_en), 1);
        check("R1 tsc_en", int'(tsc_en), 1);
        check("R1 ack", int'(snoop_ack), 0);

        // R5 Normal snoop acknowledged same cycle
        snoop_req = 1'b1; #1;
        check("R5 normal ack", int'(snoop_ack), 1);
        tick();
        check("R5 normal no move", int'(cur_state), 0);
        snoop_req = 1'b0;

        // R2 stop-clock beats halt
        halt_req = 1'b1; stop_clk_n = 1'b0;
        tick();
        halt_req = 1'b0;
        check("R2 priority", int'(cur_state), 2);
        check("R10 qs tsc", int'(tsc_en), 0);

        // R4 stop exit
        stop_clk_n = 1'b1;
        tick();
        ticks(QS - 2);
        check("R9 clk_en early", int'(core_clk_en), 0);
        tick();
        check("R9 clk_en last", int'(core_clk_en), 1);
        check("R4 not yet", int'(cur_state), 2);
        tick();
        check("R4 normal", int'(cur_state), 0);

        // R2 halt entry
        halt_req = 1'b1; tick(); halt_req = 1'b0;
        check("R2 halt", int'(cur_state), 1);
        check("R10 ah tsc", int'(tsc_en), 1);

        // R5/R6 snoop from Auto Halt
        snoop_req = 1'b1; tick(); snoop_req = 1'b0;
        check("R5 snoop state", int'(cur_state), 3);
        check("R5 snoop ack", int'(snoop_ack), 1);
        tick();
        check("R6 waits done", int'(cur_state), 3);
        snoop_done = 1'b1; tick(); snoop_done = 1'b0;
        ticks(RET - 1);
        check("R6 before return", int'(cur_state), 3);
        tick();
        check("R6 back to ah", int'(cur_state), 1);

        // R3 with R11 strobes inside the countdown
        wake_req = 1'b1; tick(); wake_req = 1'b0;
        ticks(2);
        snoop_req = 1'b1; halt_req = 1'b1; snoop_done = 1'b1;
        tick();
        check("R11 ignored ack", int'(snoop_ack), 0);
        check("R11 ignored state", int'(cur_state), 1);
        snoop_req = 1'b0; halt_req = 1'b0; snoop_done = 1'b0;
        ticks(AH - 4);
        check("R3 not yet", int'(cur_state), 1);
        tick();
        check("R3 normal", int'(cur_state), 0);

        // Quick Start, snoop with sleep already low, return then sleep-entry
        stop_clk_n = 1'b0; tick();
        check("R9 qs clk off", int'(core_clk_en), 0);
        sleep_n = 1'b0; snoop_req = 1'b1; tick(); snoop_req = 1'b0;
        check("R7 snoop beats sleep", int'(cur_state), 3);
        snoop_done = 1'b1; tick(); snoop_done = 1'b0;
        ticks(RET);
        check("R6 back to qs", int'(cur_state), 2);
        tick();
        check("R7 sleep entry", int'(cur_state), 4);

        // R8 snoop ignored in Deep Sleep
        snoop_req = 1'b1;
        ticks(3);
        check("R8 ack low", int'(snoop_ack), 0);
        check("R8 stays", int'(cur_state), 4);
        snoop_req = 1'b0;

        // R7 sleep exit
        sleep_n = 1'b1; tick();
        ticks(DS - 1);
        check("R7 not yet", int'(cur_state), 4);
        tick();
        check("R7 back qs", int'(cur_state), 2);
        stop_clk_n = 1'b1;
        ticks(QS + 2);
        check("R4 normal again", int'(cur_state), 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            halt_req   = ($urandom % 8) == 0;
            wake_req   = ($urandom % 8) == 0;
            snoop_req  = ($urandom % 4) == 0;
            snoop_done = ($urandom % 4) == 0;
            if (($urandom % 16) == 0) stop_clk_n = ~stop_clk_n;
            if (($urandom % 16) == 0) sleep_n = ~sleep_n;
            tick();
        end

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule